// File: doc/BRIEF.md
# Per-Pin Input Debounce Bank

This block filters a bank of general-purpose input pins before they reach the port and interrupt logic. Every pin passes through a two-stage synchronizer. A per-pin filter then either hands the synchronized level straight on, or holds it back until it has been seen stable across two consecutive samples. A debounced pin samples on every base clock by default. When its divider enable is also set, it samples only on a tick from one shared programmable divider. That tick lengthens the debounce window for all such pins together.

Software drives the block through a simple write port. The enable registers use masked halves: one word covers sixteen pins, and its upper half selects which of the lower-half value bits take effect. This lets one pin be changed without a read-modify-write. The divider value is a plain word. Writing it restarts the divider.

Top module: `pdb_bank`

## Requirements
- R1: While reset is held (at least three cycles), each filtered output loads the synchronized input level, all enables clear and the divider value becomes 0, so after reset every pin is in pass-through.
- R2: A pin with its debounce enable clear shows a change of its raw input on the filtered output exactly 3 clock edges later (two synchronizer stages plus the output register). A one-cycle pulse passes through unfiltered.
- R3: A pin with debounce enabled and divider enable clear shows a stable change 4 edges after the raw change. A pulse of one cycle never reaches the output.
- R4: Debounce enables are written at address 0x38 (pins 0 to 15) and 0x3C (pins 16 to 31): data bit 16+i set lets data bit i become the enable of pin i of that half, and bits whose mask bit is clear keep their value.
- R5: Divider enables are written at 0x40 (pins 0 to 15) and 0x44 (pins 16 to 31) with the same masked scheme.
- R6: A write to 0x48 stores data bits 23:0 as divider value v (bits 31:24 are ignored) and restarts the divider count.
- R7: The divider ticks once every 2*(v+1) cycles, first on the 2*(v+1)-th edge after a restart. A pin with both enables set samples only on ticks and takes a new level when two consecutive tick samples agree and differ from its output.
- R8: A divider enable has no effect on a pin whose debounce enable is clear; that pin stays in pass-through.
- R9: Writes to any other address change no enable and no divider state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_raw | input | NPIN (32) | Asynchronous raw pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (8) | Register byte address |
| wr_data | input | 32 | Register write data |
| pin_filt | output | NPIN (32) | Registered filtered pin levels |

## Verification
A raw change in pass-through is due on the third edge, and an undivided debounced change on the fourth. A divided pin changes on the second tick after the change reaches the synchronizer. With v=3 after a restart, that is the sixteenth edge. Inputs are driven on the falling edge and the directed checks sample on later falling edges after an exact count of rising edges, checking the old value one edge before the due edge and the new value on it. A bench reference model, written from the requirements, steps once per rising edge under random pin toggles and register writes, and every falling edge compares all outputs with it.

// File: rtl/pdb_pkg.sv
package pdb_pkg;
  localparam int unsigned HALF_W  = 16;
  localparam int unsigned OFS_DBE = 'h38;
  localparam int unsigned OFS_DEN = 'h40;
  localparam int unsigned OFS_DIV = 'h48;

  // Masked half write: upper half of d selects which lower-half bits land.
  function automatic logic [HALF_W-1:0] half_write(input logic [HALF_W-1:0] old,
                                                   input logic [31:0] d);
    return (old & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction
endpackage

// File: rtl/pdb_regs.sv
module pdb_regs #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned DIV_W  = 24,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [NPIN-1:0]   dbe_q,
  output logic [NPIN-1:0]   den_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              div_wr
);
  import pdb_pkg::*;
  localparam int unsigned NHALF = NPIN / HALF_W;
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(OFS_DIV);

  assign div_wr = wr_en && (wr_addr == A_DIV);

  always_ff @(posedge clk) begin
    if (rst) begin
      dbe_q <= '0;
      den_q <= '0;
      div_q <= '0;
    end else if (wr_en) begin
      for (int h = 0; h < NHALF; h++) begin
        if (wr_addr == ADDR_W'(OFS_DBE + 4 * h))
          dbe_q[h*HALF_W +: HALF_W] <= half_write(dbe_q[h*HALF_W +: HALF_W], wr_data);
        if (wr_addr == ADDR_W'(OFS_DEN + 4 * h))
          den_q[h*HALF_W +: HALF_W] <= half_write(den_q[h*HALF_W +: HALF_W], wr_data);
      end
      if (wr_addr == A_DIV)
        div_q <= wr_data[DIV_W-1:0];
    end
  end
endmodule

// File: rtl/pdb_tick_gen.sv
module pdb_tick_gen #(
  parameter int unsigned DIV_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic             restart,
  output logic             tick
);
  localparam int unsigned CNT_W = DIV_W + 1;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  // Period 2*(v+1): terminal count is 2v+1.
  assign lim  = {div_val, 1'b1};
  assign tick = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt <= '0;
    else if (tick)      cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pdb_pin_filter.sv
module pdb_pin_filter (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  input  logic dbe,
  input  logic den,
  input  logic tick,
  output logic sync,
  output logic filt
);
  logic s1;
  logic smp;
  logic take;

  always_ff @(posedge clk) begin
    s1   <= raw;
    sync <= s1;
  end

  assign take = !den || tick;

  always_ff @(posedge clk) begin
    if (rst || !dbe) begin
      filt <= sync;
      smp  <= sync;
    end else if (take) begin
      smp <= sync;
      if (smp == sync) filt <= sync;
    end
  end
endmodule

// File: rtl/pdb_bank.sv
module pdb_bank #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned DIV_W  = 24,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   pin_raw,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  output logic [NPIN-1:0]   pin_filt
);
  logic [NPIN-1:0]  dbe_q;
  logic [NPIN-1:0]  den_q;
  logic [DIV_W-1:0] div_q;
  logic             div_wr;
  logic             tick;
  logic [NPIN-1:0]  sync_v;

  pdb_regs #(.NPIN(NPIN), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbe_q(dbe_q), .den_q(den_q), .div_q(div_q), .div_wr(div_wr)
  );

  pdb_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div_val(div_q), .restart(div_wr), .tick(tick)
  );

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    pdb_pin_filter u_flt (
      .clk(clk), .rst(rst), .raw(pin_raw[i]), .dbe(dbe_q[i]), .den(den_q[i]),
      .tick(tick), .sync(sync_v[i]), .filt(pin_filt[i])
    );
  end
endmodule

// File: rtl/pdb_bank_chk.sv
module pdb_bank_chk #(
  parameter int unsigned NPIN   = 32,
  parameter int unsigned DIV_W  = 24,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic [NPIN-1:0]   dbe_q,
  input logic [NPIN-1:0]   den_q,
  input logic [DIV_W-1:0]  div_q,
  input logic              tick,
  input logic [NPIN-1:0]   sync_v,
  input logic [NPIN-1:0]   pin_filt
);
  import pdb_pkg::*;
  localparam int unsigned NHALF = NPIN / HALF_W;

  logic known_addr;
  always_comb begin
    known_addr = (wr_addr == ADDR_W'(OFS_DIV));
    for (int h = 0; h < NHALF; h++)
      if (wr_addr == ADDR_W'(OFS_DBE + 4 * h) || wr_addr == ADDR_W'(OFS_DEN + 4 * h))
        known_addr = 1'b1;
  end

  // R2, R3: any output change equals the synchronized level of the previous cycle
  a_r3_change_from_sync: assert property (@(posedge clk) disable iff (rst)
    ((pin_filt ^ $past(pin_filt)) & (pin_filt ^ $past(sync_v))) == '0);

  // R7: divided pins move only on a tick edge
  a_r7_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (($past(dbe_q & den_q) & ~{NPIN{$past(tick)}}) & (pin_filt ^ $past(pin_filt))) == '0);

  // R7: ticks are never back to back
  a_r7_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R6: a divider write restarts the count and keeps the low bits
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(OFS_DIV)) |=> (!tick && div_q == $past(wr_data[DIV_W-1:0])));

  // R4: a fully masked write leaves the enables of that half unchanged
  a_r4_masked_nop: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(OFS_DBE) && wr_data[31:16] == 16'h0) |=> $stable(dbe_q));

  // R9: unknown addresses touch nothing
  a_r9_other_addr: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !known_addr) |=> ($stable(dbe_q) && $stable(den_q) && $stable(div_q)));
endmodule

bind pdb_bank pdb_bank_chk #(.NPIN(NPIN), .DIV_W(DIV_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .dbe_q(dbe_q), .den_q(den_q), .div_q(div_q), .tick(tick),
  .sync_v(sync_v), .pin_filt(pin_filt)
);

// File: tb/tb_pdb_bank.sv
module tb_pdb_bank;
  localparam int NPIN = 32;
  localparam int DW   = 24;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NPIN-1:0] pin_raw = 32'hA5A5_0F0F;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [NPIN-1:0] pin_filt;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  pdb_bank #(.NPIN(NPIN), .DIV_W(DW), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .pin_raw(pin_raw), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pin_filt(pin_filt)
  );

  // Reference model built from the requirements
  logic [NPIN-1:0] m_s1, m_s2, m_out, m_smp, m_dbe, m_den;
  logic [DW-1:0]   m_div;
  logic [DW:0]     m_cnt;

  function automatic logic [15:0] mw(input logic [15:0] o, input logic [31:0] d);
    return (o & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  always @(posedge clk) begin
    logic tk;
    tk = (m_cnt == ({1'b0, m_div} * 2 + 1));
    m_s1 <= pin_raw;
    m_s2 <= m_s1;
    if (rst) begin
      m_out <= m_s2; m_smp <= m_s2; m_dbe <= '0; m_den <= '0; m_div <= '0; m_cnt <= '0;
    end else begin
      for (int i = 0; i < NPIN; i++) begin
        if (!m_dbe[i]) begin
          m_out[i] <= m_s2[i]; m_smp[i] <= m_s2[i];
        end else if (!m_den[i] || tk) begin
          m_smp[i] <= m_s2[i];
          if (m_smp[i] == m_s2[i]) m_out[i] <= m_s2[i];
        end
      end
      if (wr_en && wr_addr == 8'h48) m_cnt <= '0;
      else if (tk) m_cnt <= '0;
      else m_cnt <= m_cnt + 1'b1;
      if (wr_en) begin
        case (wr_addr)
          8'h38: m_dbe[15:0]  <= mw(m_dbe[15:0], wr_data);
          8'h3C: m_dbe[31:16] <= mw(m_dbe[31:16], wr_data);
          8'h40: m_den[15:0]  <= mw(m_den[15:0], wr_data);
          8'h44: m_den[31:16] <= mw(m_den[31:16], wr_data);
          8'h48: m_div        <= wr_data[DW-1:0];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // Every falling edge: whole-bank compare against the model (R2, R3, R5, R7, R8)
  always @(negedge clk) begin
    if (cmp_on && !done) chk("R7 model", pin_filt, m_out);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic steps(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] old;
    void'($urandom(32'd4711));
    steps(5);
    rst = 1'b0;
    chk("R1 reset load", pin_filt, 32'hA5A5_0F0F);
    cmp_on = 1'b1;

    // R2 pass-through latency
    old = pin_raw; pin_raw = ~pin_raw;
    steps(2); chk("R2 before", pin_filt, old);
    steps(1); chk("R2 due", pin_filt, ~old);
    // R2 single-cycle pulse passes
    pin_raw[0] = 1'b1; steps(1); pin_raw[0] = 1'b0;
    steps(2); chk("R2 pulse seen", {31'b0, pin_filt[0]}, 32'd1);
    steps(1); chk("R2 pulse gone", {31'b0, pin_filt[0]}, 32'd0);

    // R3 undivided debounce
    wr(8'h38, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF); steps(2);
    old = pin_raw; pin_raw = ~pin_raw;
    steps(3); chk("R3 before", pin_filt, old);
    steps(1); chk("R3 due", pin_filt, ~old);
    pin_raw[0] = 1'b0; steps(1); pin_raw[0] = 1'b1;
    for (int k = 0; k < 6; k++) begin
      steps(1); chk("R3 pulse dropped", {31'b0, pin_filt[0]}, 32'd1);
    end

    // R9 write to an unused address
    wr(8'h50, 32'hFFFF_0000); wr(8'h34, 32'hFFFF_0000); steps(2);
    pin_raw[5] = ~pin_raw[5];
    steps(3); chk("R9 still debounced", {31'b0, pin_filt[5]}, {31'b0, ~pin_raw[5]});
    steps(1); chk("R9 due", {31'b0, pin_filt[5]}, {31'b0, pin_raw[5]});

    // R4 masked write clears only pin 0
    wr(8'h38, 32'h0001_0000); steps(2);
    old = pin_raw; pin_raw[1:0] = ~pin_raw[1:0];
    steps(3); chk("R4 pin0 pass, pin1 held", {30'b0, pin_filt[1:0]}, {30'b0, old[1], pin_raw[0]});
    steps(1); chk("R4 pin1 due", {30'b0, pin_filt[1:0]}, {30'b0, pin_raw[1:0]});

    // R5 den low half, R6 divider v=3 with upper bits ignored, R7 window, R8
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h44, 32'h0000_FFFF);
    steps(3);
    wr(8'h48, 32'hFF00_0003);
    old = pin_raw; pin_raw[1:0] = ~pin_raw[1:0]; pin_raw[16] = ~pin_raw[16];
    steps(3); chk("R8 den without dbe", {31'b0, pin_filt[0]}, {31'b0, pin_raw[0]});
    steps(1); chk("R5 pin16 undivided", {31'b0, pin_filt[16]}, {31'b0, pin_raw[16]});
    steps(11); chk("R7 before window", {31'b0, pin_filt[1]}, {31'b0, old[1]});
    steps(1); chk("R6 R7 window due", {31'b0, pin_filt[1]}, {31'b0, pin_raw[1]});

    // Random phase, checked by the model every falling edge
    for (int n = 0; n < 4000; n++) begin
      pin_raw = pin_raw ^ ($urandom & $urandom & $urandom & $urandom);
      if (($urandom % 16) == 0) begin
        case ($urandom % 6)
          0: wr(8'h38, $urandom);
          1: wr(8'h3C, $urandom);
          2: wr(8'h40, $urandom);
          3: wr(8'h44, $urandom);
          4: wr(8'h48, ($urandom & 32'hFF00_0000) | ($urandom % 6));
          default: wr(8'h50, $urandom);
        endcase
      end else begin
        steps(1);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule